// File: doc/BRIEF.md
# Masked-Write GPIO Port with Pin Interrupts

A sixteen-pin general-purpose I/O port that sits on a simple register bus. Software samples every pin through one input register. It updates output values through two byte-wide windows whose address carries a lane mask, so one write can change any subset of a byte and leave the other bits alone without a read-modify-write. Output enables, interrupt type, interrupt polarity and interrupt enables each have a set alias and a clear alias, so single bits can change without disturbing their neighbours.

Every pin passes through a two-flop synchroniser. Each pin can raise a level or an edge interrupt of either polarity. Triggered pins latch into a pending register that is cleared by writing ones. A single combined interrupt line reports any pending pin that is also enabled.

Top module: `gpio_mport`

## Requirements
- R1: After reset, pins_out, pins_oe, irq and every control and pending bit are 0.
- R2: A read of word 0 (bus_addr = 0x000) returns the pin levels after two clock edges of synchronisation, whether or not the output enable is set for a pin.
- R3: A write with bus_addr[9:8] = 01 updates pins_out[i] to bus_wdata[i] for each i in 0..7 with bus_addr[i] = 1. All other output bits keep their value. A read of word 1 returns pins_out.
- R4: A write with bus_addr[9:8] = 10 updates pins_out[8+j] to bus_wdata[8+j] for each j in 0..7 with bus_addr[j] = 1. All other output bits keep their value.
- R5: A write to word 2 sets, and a write to word 3 clears, each output enable whose data bit is 1. Bits written as 0 are unchanged. A read of either word returns the enables.
- R6: Interrupt type (words 4 set / 5 clear, 0 = level, 1 = edge), polarity (words 6 / 7, 0 = low or falling, 1 = high or rising) and interrupt enable (words 8 / 9) follow the same set/clear rule. A read of either word returns the value.
- R7: An enabled level pin whose synchronised level equals its polarity becomes pending. It becomes pending again on every cycle in which the level still holds, including the cycle of a clear.
- R8: An enabled edge pin becomes pending on the synchronised edge that its polarity selects, and stays pending until cleared. The opposite edge does not set it.
- R9: A read of word 10 returns the pending bits. Writing 1s there clears those bits and 0s leave bits alone. An edge that arrives in the same cycle as its clear leaves the bit pending.
- R10: irq is the OR of all bits that are both pending and enabled. A pin whose interrupt is disabled never becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address; bits 9:8 pick the region, bits 7:0 hold a mask in the windows |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| pins_in | input | 16 | Asynchronous pin levels |
| pins_out | output | 16 | Output values |
| pins_oe | output | 16 | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check the following. A low-window write leaves the high output byte unchanged, and a high-window write leaves the low byte unchanged. Set and clear writes to the enables take effect on the next cycle. Outputs hold when there is no write. irq is never raised without a pending bit. Only the bench scenarios can show the interrupt semantics, because they depend on pin history: level re-assertion after a clear, rejection of the opposite edge, masking by the enable, and an edge that beats a clear arriving in the same cycle. The bench also shows the input path across random pin patterns.

// File: rtl/gpio_mport_pkg.sv
package gpio_mport_pkg;
    localparam int PORT_W = 16;
    localparam int HALF_W = PORT_W / 2;
    localparam int ADDR_W = 10;
    localparam int IDX_W  = 4;

    localparam logic [1:0] RGN_CTRL = 2'b00;
    localparam logic [1:0] RGN_LOW  = 2'b01;
    localparam logic [1:0] RGN_HIGH = 2'b10;

    typedef enum logic [IDX_W-1:0] {
        W_DIN     = 4'd0,
        W_DOUT    = 4'd1,
        W_OE_SET  = 4'd2,
        W_OE_CLR  = 4'd3,
        W_TYP_SET = 4'd4,
        W_TYP_CLR = 4'd5,
        W_POL_SET = 4'd6,
        W_POL_CLR = 4'd7,
        W_IEN_SET = 4'd8,
        W_IEN_CLR = 4'd9,
        W_STAT    = 4'd10
    } word_e;

    typedef struct packed {
        logic [PORT_W-1:0] dout;
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] typ;
        logic [PORT_W-1:0] pol;
        logic [PORT_W-1:0] ien;
    } ctrl_t;
endpackage

// File: rtl/gpio_mport_sync.sv
module gpio_mport_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync = st_q.chain[STAGES-1];
    assign prev = st_q.prev;
endmodule

// File: rtl/gpio_mport_irq.sv
module gpio_mport_irq #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] typ,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] ien,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend,
    output logic         irq
);
    logic [W-1:0] pend_d, pend_q;
    logic [W-1:0] lvl_hit, edge_hit, cond;

    always_comb begin
        lvl_hit  = ~(lvl ^ pol);
        edge_hit = (pol & lvl & ~prev) | (~pol & ~lvl & prev);
        cond     = ien & ((typ & edge_hit) | (~typ & lvl_hit));
        // a new trigger outranks a clear in the same cycle
        pend_d   = (pend_q & ~clr) | cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
    assign irq  = |(pend_q & ien);
endmodule

// File: rtl/gpio_mport.sv
module gpio_mport
    import gpio_mport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pins_in,
    output logic [PORT_W-1:0] pins_out,
    output logic [PORT_W-1:0] pins_oe,
    output logic              irq
);
    ctrl_t ctrl_d, ctrl_q;

    logic [PORT_W-1:0] pin_sync, pin_prev, irq_pend, stat_clr;
    logic [1:0]        region;
    logic [IDX_W-1:0]  idx;
    logic [HALF_W-1:0] lane;
    logic              wr_en;

    assign region = bus_addr[ADDR_W-1:ADDR_W-2];
    assign idx    = bus_addr[IDX_W-1:0];
    assign lane   = bus_addr[HALF_W-1:0];
    assign wr_en  = bus_sel & bus_wr;

    gpio_mport_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_in),
        .sync (pin_sync),
        .prev (pin_prev)
    );

    gpio_mport_irq #(.W(PORT_W)) u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (pin_sync),
        .prev (pin_prev),
        .typ  (ctrl_q.typ),
        .pol  (ctrl_q.pol),
        .ien  (ctrl_q.ien),
        .clr  (stat_clr),
        .pend (irq_pend),
        .irq  (irq)
    );

    always_comb begin
        ctrl_d   = ctrl_q;
        stat_clr = '0;
        if (wr_en) begin
            unique case (region)
                RGN_LOW: begin
                    ctrl_d.dout[HALF_W-1:0] = (ctrl_q.dout[HALF_W-1:0] & ~lane)
                                            | (bus_wdata[HALF_W-1:0] & lane);
                end
                RGN_HIGH: begin
                    ctrl_d.dout[PORT_W-1:HALF_W] = (ctrl_q.dout[PORT_W-1:HALF_W] & ~lane)
                                                 | (bus_wdata[PORT_W-1:HALF_W] & lane);
                end
                RGN_CTRL: begin
                    case (idx)
                        W_OE_SET:  ctrl_d.oe  = ctrl_q.oe  |  bus_wdata;
                        W_OE_CLR:  ctrl_d.oe  = ctrl_q.oe  & ~bus_wdata;
                        W_TYP_SET: ctrl_d.typ = ctrl_q.typ |  bus_wdata;
                        W_TYP_CLR: ctrl_d.typ = ctrl_q.typ & ~bus_wdata;
                        W_POL_SET: ctrl_d.pol = ctrl_q.pol |  bus_wdata;
                        W_POL_CLR: ctrl_d.pol = ctrl_q.pol & ~bus_wdata;
                        W_IEN_SET: ctrl_d.ien = ctrl_q.ien |  bus_wdata;
                        W_IEN_CLR: ctrl_d.ien = ctrl_q.ien & ~bus_wdata;
                        W_STAT:    stat_clr   = bus_wdata;
                        default:   ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (region == RGN_CTRL) begin
            case (idx)
                W_DIN:                bus_rdata = pin_sync;
                W_DOUT:               bus_rdata = ctrl_q.dout;
                W_OE_SET,  W_OE_CLR:  bus_rdata = ctrl_q.oe;
                W_TYP_SET, W_TYP_CLR: bus_rdata = ctrl_q.typ;
                W_POL_SET, W_POL_CLR: bus_rdata = ctrl_q.pol;
                W_IEN_SET, W_IEN_CLR: bus_rdata = ctrl_q.ien;
                W_STAT:               bus_rdata = irq_pend;
                default:              bus_rdata = '0;
            endcase
        end
    end

    assign pins_out = ctrl_q.dout;
    assign pins_oe  = ctrl_q.oe;
endmodule

// File: rtl/gpio_mport_chk.sv
module gpio_mport_chk
    import gpio_mport_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] pins_out,
    input logic [PORT_W-1:0] pins_oe,
    input logic              irq,
    input logic [PORT_W-1:0] pend
);
    logic wr_low, wr_high, wr_oe_set, wr_oe_clr, any_wr;

    assign any_wr    = bus_sel && bus_wr;
    assign wr_low    = any_wr && bus_addr[ADDR_W-1:ADDR_W-2] == RGN_LOW;
    assign wr_high   = any_wr && bus_addr[ADDR_W-1:ADDR_W-2] == RGN_HIGH;
    assign wr_oe_set = any_wr && bus_addr == ADDR_W'(W_OE_SET);
    assign wr_oe_clr = any_wr && bus_addr == ADDR_W'(W_OE_CLR);

    assert_low_keeps_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_low |=> pins_out[PORT_W-1:HALF_W] == $past(pins_out[PORT_W-1:HALF_W]));

    assert_high_keeps_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_high |=> pins_out[HALF_W-1:0] == $past(pins_out[HALF_W-1:0]));

    assert_oe_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_oe_set |=> (pins_oe & $past(bus_wdata)) == $past(bus_wdata));

    assert_oe_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_oe_clr |=> (pins_oe & $past(bus_wdata)) == '0);

    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> $stable(pins_out) && $stable(pins_oe));

    assert_irq_needs_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend != '0);
endmodule

bind gpio_mport gpio_mport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pins_out (pins_out),
    .pins_oe  (pins_oe),
    .irq      (irq),
    .pend     (irq_pend)
);

// File: tb/gpio_mport_test.sv
`timescale 1ns/1ps
module gpio_mport_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pins_in = '0;
    logic [15:0] pins_out, pins_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] m_out = '0;
    logic [15:0] m_oe  = '0;

    always #10 clk = ~clk;

    gpio_mport uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe), .irq(irq)
    );

    function automatic logic [9:0] word(int n);
        return 10'(n);
    endfunction
    function automatic logic [15:0] merge_low(logic [15:0] cur, logic [7:0] m, logic [15:0] d);
        return {cur[15:8], (cur[7:0] & ~m) | (d[7:0] & m)};
    endfunction
    function automatic logic [15:0] merge_high(logic [15:0] cur, logic [7:0] m, logic [15:0] d);
        return {(cur[15:8] & ~m) | (d[15:8] & m), cur[7:0]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] r;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 pins_out", pins_out, 16'h0);
        check("R1 pins_oe", pins_oe, 16'h0);
        check("R1 irq", {15'h0, irq}, 16'h0);
        rst_n = 1'b1;
        rd(word(10), r); check("R1 pending", r, 16'h0);
        rd(word(8), r);  check("R1 ien", r, 16'h0);

        // R3/R4 directed: mask of zero changes nothing, full mask writes all
        wr({2'b01, 8'h00}, 16'hFFFF); rd(word(1), r); check("R3 empty mask", r, 16'h0);
        wr({2'b10, 8'hFF}, 16'hA5A5); m_out = merge_high(m_out, 8'hFF, 16'hA5A5);
        rd(word(1), r); check("R4 full high", r, m_out);

        // R3/R4/R5 random
        for (int i = 0; i < 200; i++) begin
            int op;
            logic [7:0]  m;
            logic [15:0] d;
            op = $urandom_range(0, 3);
            m  = 8'($urandom);
            d  = 16'($urandom);
            case (op)
                0: begin wr({2'b01, m}, d); m_out = merge_low(m_out, m, d); end
                1: begin wr({2'b10, m}, d); m_out = merge_high(m_out, m, d); end
                2: begin wr(word(2), d); m_oe = m_oe | d; end
                default: begin wr(word(3), d); m_oe = m_oe & ~d; end
            endcase
            rd(word(1), r); check(op < 2 ? "R3/R4 dout" : "R5 dout unchanged", r, m_out);
            rd(word(op == 3 ? 3 : 2), r); check("R5 oe read", r, m_oe);
            check("R5 pins_oe", pins_oe, m_oe);
        end

        // R6 set/clear aliases
        wr(word(4), 16'h00F0); wr(word(5), 16'h0030); rd(word(4), r); check("R6 type", r, 16'h00C0);
        wr(word(6), 16'h0F00); wr(word(7), 16'h0100); rd(word(7), r); check("R6 polarity", r, 16'h0E00);
        wr(word(8), 16'h1234); wr(word(9), 16'h0204); rd(word(9), r); check("R6 ien", r, 16'h1030);
        wr(word(5), 16'hFFFF); wr(word(7), 16'hFFFF); wr(word(9), 16'hFFFF);
        settle(); wr(word(10), 16'hFFFF);

        // R2 random input levels, independent of output enable
        wr(word(2), 16'hFFFF);
        for (int i = 0; i < 20; i++) begin
            logic [15:0] p;
            p = 16'($urandom);
            @(negedge clk); pins_in = p;
            repeat (3) @(posedge clk);
            rd(word(0), r); check("R2 din", r, p);
        end
        @(negedge clk); pins_in = '0; settle();

        // R10 disabled pin never pends
        wr(word(4), 16'h0001); wr(word(6), 16'h0001);
        @(negedge clk); pins_in[0] = 1'b1; settle();
        rd(word(10), r); check("R10 disabled no pend", r, 16'h0);
        check("R10 irq low", {15'h0, irq}, 16'h0);
        @(negedge clk); pins_in[0] = 1'b0; settle();

        // R8 rising edge on pin 0, falling does not trigger
        wr(word(8), 16'h0001);
        @(negedge clk); pins_in[0] = 1'b1; settle();
        rd(word(10), r); check("R8 rising pends", r, 16'h0001);
        check("R10 irq high", {15'h0, irq}, 16'h0001);
        wr(word(10), 16'h0001);
        rd(word(10), r); check("R9 clear", r, 16'h0);
        @(negedge clk); pins_in[0] = 1'b0; settle();
        rd(word(10), r); check("R8 opposite edge ignored", r, 16'h0);
        @(negedge clk); pins_in[0] = 1'b1; settle();
        @(negedge clk); pins_in[0] = 1'b0; settle();
        rd(word(10), r); check("R8 sticky", r, 16'h0001);
        wr(word(10), 16'h0000); rd(word(10), r); check("R9 zero keeps", r, 16'h0001);

        // R9 edge in the same cycle as its clear wins
        @(negedge clk); pins_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        wr(word(10), 16'h0001);
        rd(word(10), r); check("R9 edge beats clear", r, 16'h0001);
        wr(word(10), 16'h0001); rd(word(10), r); check("R9 clear after", r, 16'h0);

        // R8 falling polarity on pin 3
        wr(word(4), 16'h0008); wr(word(8), 16'h0008);
        @(negedge clk); pins_in[3] = 1'b1; settle();
        rd(word(10), r); check("R8 falling ignores rise", r, 16'h0);
        @(negedge clk); pins_in[3] = 1'b0; settle();
        rd(word(10), r); check("R8 falling pends", r, 16'h0008);
        wr(word(10), 16'h0008);

        // R7 level high on pin 5 re-asserts while held
        wr(word(6), 16'h0020); wr(word(8), 16'h0020);
        @(negedge clk); pins_in[5] = 1'b1; settle();
        rd(word(10), r); check("R7 level pends", r, 16'h0020);
        wr(word(10), 16'h0020);
        rd(word(10), r); check("R7 re-asserts", r, 16'h0020);
        @(negedge clk); pins_in[5] = 1'b0; settle();
        wr(word(10), 16'h0020);
        rd(word(10), r); check("R7 released", r, 16'h0);
        // R7 active-low level on pin 6
        wr(word(8), 16'h0040); settle();
        rd(word(10), r); check("R7 low level pends", r, 16'h0040);
        wr(word(9), 16'h0040); wr(word(10), 16'h0040);
        rd(word(10), r); check("R10 disable stops pend", r, 16'h0);
        check("R10 irq clear", {15'h0, irq}, 16'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule